// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block drives the column side of one SDRAM read or write burst. A mode-set command loads a small mode register with the burst length, the address order and the CAS latency. A read or write command then supplies the starting column. From the next cycle the block puts one column address per beat on its output, and it marks each beat as a read beat or a write beat.

For reads, a data-valid strobe follows the beats after the programmed CAS latency. Per-byte output enables turn a byte off two clocks after its mask bit is sampled. For writes, per-byte write enables follow the mask in the same cycle. A controller places the block between its command decoder and the DRAM pins. Bank and row handling, refresh and the memory array are not part of it.

A new read or write cuts off the burst in progress. A burst-stop command ends the beats. A full-page burst wraps over the whole column range until it is stopped.

Top module: `sdr_burst_seq`

## Requirements
- R1: `cmd_i` codes are 0 no-op, 1 mode set, 2 read, 3 write, 4 burst stop. On a mode set, `addr_i[2:0]` selects the length (0:1, 1:2, 2:4, 3:8, 7:full page, any other code:1), `addr_i[3]`=1 selects interleaved order, and `addr_i[6:4]`=2 selects CAS latency 2 (any other value gives 3).
- R2: While reset is held and after it is released, every output strobe and enable is low, and the mode is length 1, sequential order, CAS latency 3.
- R3: When a read or write is accepted in cycle c, beat i shows its column on `col_o` with `beat_o` high in cycle c+1+i. `beat_o` is low after the last beat.
- R4: In sequential order the column is the start plus the beat index, wrapped inside the aligned block of the burst length.
- R5: In interleaved order the low bits of the column are the start's low bits XOR the beat index, and the upper bits are kept.
- R6: A full-page burst counts up sequentially over the whole column range, wraps from the top column to 0, and runs until a stop or a new read or write. The order bit has no effect at full page.
- R7: For a read accepted in cycle c, `rd_valid_o` is high in cycles c+CL through c+CL+len-1.
- R8: During read data, `dq_oe_o[b]` is low in cycle d+2 when `dm_i[b]` was high in cycle d. Otherwise it follows `rd_valid_o`.
- R9: `beat_wr_o` is high on write beats. In such a cycle `wr_en_o[b]` is high unless `dm_i[b]` is high in that same cycle.
- R10: A read or write accepted during a burst makes the next cycle show beat 0 at the new start column, and a full new burst follows.
- R11: A burst stop accepted in cycle s leaves `beat_o` low from cycle s+1.
- R12: Any command in the cycle right after an accepted mode set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command code |
| addr_i | input | COL_W | Start column, or mode key on mode set |
| dm_i | input | NBYTES | Per-byte data mask |
| col_o | output | COL_W | Column address of the current beat |
| beat_o | output | 1 | Beat active |
| beat_wr_o | output | 1 | Current beat is a write beat |
| rd_valid_o | output | 1 | Read data valid |
| dq_oe_o | output | NBYTES | Per-byte read output enable |
| wr_en_o | output | NBYTES | Per-byte write enable |

## Verification
A vector table runs sequential and interleaved bursts of lengths 1, 2, 4 and 8 from unaligned starts. Using the same start in both orders separates the add-and-wrap rule from the XOR rule, and a reserved length code shows the fallback to a single beat. Directed runs cover the remaining cases:
- Back-to-back reads at latency 2 and 3, which separate the two pipeline taps.
- A mask pulse placed inside a read, which shows the two-clock delay, and one inside a write, which shows the zero-clock path.
- A full-page run that wraps past the top column with the order bit set.
- An interrupting read and a stop, which cut a burst short.
- Commands in the cycle after a mode set, which must be ignored.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MODE  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_STOP  = 3'd4
  } cmd_e;

  localparam logic [2:0] LEN_FULL = 3'd7;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic       cl2;
  } mode_t;

  localparam mode_t MODE_RST = '{len_code: 3'd0, ilv: 1'b0, cl2: 1'b0};
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cmd_i,
  input  logic [6:0] key_i,
  output mode_t      mode_o,
  output logic       mode_go_o,
  output logic       rd_go_o,
  output logic       wr_go_o,
  output logic       stop_go_o
);
  logic  lock_q;
  mode_t mode_q;

  assign mode_go_o = !lock_q && (cmd_i == CMD_MODE);
  assign rd_go_o   = !lock_q && (cmd_i == CMD_READ);
  assign wr_go_o   = !lock_q && (cmd_i == CMD_WRITE);
  assign stop_go_o = !lock_q && (cmd_i == CMD_STOP);
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      mode_q <= MODE_RST;
    end else begin
      lock_q <= mode_go_o;
      if (mode_go_o) begin
        mode_q.len_code <= key_i[2:0];
        // full page is always sequential
        mode_q.ilv      <= key_i[3] && (key_i[2:0] != LEN_FULL);
        mode_q.cl2      <= (key_i[6:4] == 3'd2);
      end
    end
  end

  p_mode_lock_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_go_o |=> !(mode_go_o || rd_go_o || wr_go_o || stop_go_o));
endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
  import sdr_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_t            mode_i,
  input  logic             rd_go_i,
  input  logic             wr_go_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_o,
  output logic             beat_rd_o,
  output logic             beat_wr_o
);
  logic             active_q, rd_q;
  logic [COL_W-1:0] start_q, cnt_q, mask, offs;
  logic             full, go;

  assign full = (mode_i.len_code == LEN_FULL);
  assign go   = rd_go_i || wr_go_i;

  always_comb begin
    unique case (mode_i.len_code)
      3'd1:     mask = COL_W'(1);
      3'd2:     mask = COL_W'(3);
      3'd3:     mask = COL_W'(7);
      LEN_FULL: mask = '1;
      default:  mask = '0;
    endcase
  end

  assign offs      = mode_i.ilv ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign col_o     = (start_q & ~mask) | (offs & mask);
  assign beat_o    = active_q;
  assign beat_rd_o = active_q && rd_q;
  assign beat_wr_o = active_q && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      start_q  <= '0;
      cnt_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      rd_q     <= rd_go_i;
      start_q  <= start_i;
      cnt_q    <= '0;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (!full && cnt_q == mask) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_stop_ends_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !go) |=> !beat_o);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (beat_o && col_o == $past(start_i)));

  p_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !full && !go && !stop_i && cnt_q != mask) |=>
      (!$stable(mode_i) || (beat_o && ((col_o & ~mask) == $past(col_o & ~mask)))));
endmodule

// File: rtl/sdr_dq_ctrl.sv
module sdr_dq_ctrl #(
  parameter int NBYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl2_i,
  input  logic              beat_rd_i,
  input  logic              beat_wr_i,
  input  logic [NBYTES-1:0] dm_i,
  output logic              rd_valid_o,
  output logic [NBYTES-1:0] dq_oe_o,
  output logic [NBYTES-1:0] wr_en_o
);
  logic              rd_p1_q, rd_p2_q;
  logic [NBYTES-1:0] dm_p1_q, dm_p2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_p1_q <= 1'b0;
      rd_p2_q <= 1'b0;
      dm_p1_q <= '0;
      dm_p2_q <= '0;
    end else begin
      rd_p1_q <= beat_rd_i;
      rd_p2_q <= rd_p1_q;
      dm_p1_q <= dm_i;
      dm_p2_q <= dm_p1_q;
    end
  end

  // beat is already one cycle after the command, so tap CL-1 stages on
  assign rd_valid_o = cl2_i ? rd_p1_q : rd_p2_q;
  assign dq_oe_o    = {NBYTES{rd_valid_o}} & ~dm_p2_q;
  assign wr_en_o    = {NBYTES{beat_wr_i}} & ~dm_i;

  p_rd_lat2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_rd_i && cl2_i) |=> (!cl2_i || rd_valid_o));

  p_rd_lat3_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_rd_i && !cl2_i) |=> ##1 (cl2_i || rd_valid_o));

  p_rd_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (dq_oe_o == ~$past(dm_i, 2)));
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int NBYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [COL_W-1:0]  addr_i,
  input  logic [NBYTES-1:0] dm_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_o,
  output logic              beat_wr_o,
  output logic              rd_valid_o,
  output logic [NBYTES-1:0] dq_oe_o,
  output logic [NBYTES-1:0] wr_en_o
);
  localparam int KEY_W = 7;

  mode_t mode;
  logic  mode_go, rd_go, wr_go, stop_go, beat_rd;

  sdr_mode_reg i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .key_i     (addr_i[KEY_W-1:0]),
    .mode_o    (mode),
    .mode_go_o (mode_go),
    .rd_go_o   (rd_go),
    .wr_go_o   (wr_go),
    .stop_go_o (stop_go)
  );

  sdr_col_gen #(.COL_W(COL_W)) i_col (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .rd_go_i   (rd_go),
    .wr_go_i   (wr_go),
    .stop_i    (stop_go),
    .start_i   (addr_i),
    .col_o     (col_o),
    .beat_o    (beat_o),
    .beat_rd_o (beat_rd),
    .beat_wr_o (beat_wr_o)
  );

  sdr_dq_ctrl #(.NBYTES(NBYTES)) i_dq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cl2_i      (mode.cl2),
    .beat_rd_i  (beat_rd),
    .beat_wr_i  (beat_wr_o),
    .dm_i       (dm_i),
    .rd_valid_o (rd_valid_o),
    .dq_oe_o    (dq_oe_o),
    .wr_en_o    (wr_en_o)
  );

  p_no_beat_after_mode_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_go && !beat_o) |=> ##1 !beat_o);
endmodule

// File: tb/test_sdr_burst_seq.sv
module test_sdr_burst_seq;
  import sdr_seq_pkg::*;

  localparam int COL_W  = 10;
  localparam int NBYTES = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        cmd_i = CMD_NOP;
  logic [COL_W-1:0]  addr_i = '0;
  logic [NBYTES-1:0] dm_i = '0;
  logic [COL_W-1:0]  col_o;
  logic              beat_o, beat_wr_o, rd_valid_o;
  logic [NBYTES-1:0] dq_oe_o, wr_en_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  sdr_burst_seq #(.COL_W(COL_W), .NBYTES(NBYTES)) i_sdr_burst_seq (
    .clk_i, .rst_ni, .cmd_i, .addr_i, .dm_i,
    .col_o, .beat_o, .beat_wr_o, .rd_valid_o, .dq_oe_o, .wr_en_o
  );

  typedef struct packed {
    logic        wr;
    logic [6:0]  key;
    logic [9:0]  start;
    logic [3:0]  len;
    logic [79:0] cols;   // beat i at [i*10 +: 10]
  } vec_t;

  localparam vec_t VECS [8] = '{
    {1'b0, {3'd3,1'b0,3'd2}, 10'd5,  4'd4, {10'd0,10'd0,10'd0,10'd0,10'd4,10'd7,10'd6,10'd5}},
    {1'b1, {3'd3,1'b1,3'd2}, 10'd5,  4'd4, {10'd0,10'd0,10'd0,10'd0,10'd6,10'd7,10'd4,10'd5}},
    {1'b0, {3'd2,1'b0,3'd3}, 10'd11, 4'd8, {10'd10,10'd9,10'd8,10'd15,10'd14,10'd13,10'd12,10'd11}},
    {1'b1, {3'd3,1'b1,3'd3}, 10'd11, 4'd8, {10'd12,10'd13,10'd14,10'd15,10'd8,10'd9,10'd10,10'd11}},
    {1'b0, {3'd3,1'b0,3'd1}, 10'd7,  4'd2, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd6,10'd7}},
    {1'b0, {3'd3,1'b1,3'd1}, 10'd6,  4'd2, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd7,10'd6}},
    {1'b1, {3'd3,1'b0,3'd0}, 10'd9,  4'd1, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd9}},
    {1'b0, {3'd3,1'b0,3'd5}, 10'h2A, 4'd1, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'h2A}}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [COL_W-1:0] a);
    @(negedge clk_i);
    cmd_i  = c;
    addr_i = a;
    @(negedge clk_i);
    cmd_i  = CMD_NOP;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R2 reset state
    repeat (3) @(negedge clk_i);
    chk("R2 beat in reset", beat_o, 0);
    chk("R2 rd_valid in reset", rd_valid_o, 0);
    chk("R2 dq_oe in reset", dq_oe_o, 0);
    chk("R2 wr_en in reset", wr_en_o, 0);
    rst_ni = 1'b1;

    // R2 default mode: length 1, CL3
    issue(CMD_READ, 10'h3F);
    chk("R2 default col", col_o, 10'h3F);
    chk("R2 default beat", beat_o, 1);
    chk("R7 rd_valid c+1", rd_valid_o, 0);
    @(negedge clk_i);
    chk("R2 default length 1", beat_o, 0);
    chk("R7 rd_valid c+2 at CL3", rd_valid_o, 0);
    @(negedge clk_i);
    chk("R7 rd_valid c+3 at CL3", rd_valid_o, 1);
    @(negedge clk_i);
    chk("R7 rd_valid ends", rd_valid_o, 0);

    // vector table: R1 R3 R4 R5 R9
    foreach (VECS[v]) begin
      issue(CMD_MODE, COL_W'(VECS[v].key));
      issue(VECS[v].wr ? CMD_WRITE : CMD_READ, VECS[v].start);
      chk("R9 beat kind", beat_wr_o, VECS[v].wr);
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        chk(VECS[v].key[3] ? "R5 interleaved col" : "R4 sequential col",
            col_o, VECS[v].cols[i*10 +: 10]);
        chk("R3 beat high", beat_o, 1);
        @(negedge clk_i);
      end
      chk("R3 beat low after burst R1", beat_o, 0);
    end

    // R7 R8 CL2 read with mask pulse
    issue(CMD_MODE, COL_W'({3'd2,1'b0,3'd2}));
    issue(CMD_READ, 10'd0);
    chk("R7 CL2 c+1", rd_valid_o, 0);
    dm_i = 8'h01;
    @(negedge clk_i);
    chk("R7 CL2 c+2", rd_valid_o, 1);
    chk("R8 unmasked", dq_oe_o, 8'hFF);
    dm_i = 8'h00;
    @(negedge clk_i);
    chk("R8 masked two clocks later", dq_oe_o, 8'hFE);
    @(negedge clk_i);
    chk("R8 mask released", dq_oe_o, 8'hFF);
    @(negedge clk_i);
    chk("R7 CL2 last beat", rd_valid_o, 1);
    @(negedge clk_i);
    chk("R7 CL2 after burst", rd_valid_o, 0);

    // R9 write mask same cycle
    issue(CMD_MODE, COL_W'({3'd3,1'b0,3'd1}));
    issue(CMD_WRITE, 10'h10);
    dm_i = 8'h0F;
    #1;
    chk("R9 write masked", wr_en_o, 8'hF0);
    chk("R9 write beat", beat_wr_o, 1);
    @(negedge clk_i);
    dm_i = 8'h00;
    #1;
    chk("R9 write unmasked", wr_en_o, 8'hFF);
    @(negedge clk_i);
    chk("R9 write over", wr_en_o, 8'h00);

    // R10 interrupt
    issue(CMD_MODE, COL_W'({3'd3,1'b0,3'd3}));
    issue(CMD_READ, 10'd0);
    @(negedge clk_i);
    chk("R10 before interrupt", col_o, 10'd1);
    cmd_i = CMD_READ;
    addr_i = 10'h20;
    @(negedge clk_i);
    cmd_i = CMD_NOP;
    chk("R10 new start", col_o, 10'h20);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk_i);
      chk("R10 new burst col", col_o, 10'h20 + i);
    end
    @(negedge clk_i);
    chk("R10 new burst ends", beat_o, 0);

    // R11 stop
    issue(CMD_READ, 10'h40);
    cmd_i = CMD_STOP;
    @(negedge clk_i);
    cmd_i = CMD_NOP;
    chk("R11 stopped", beat_o, 0);
    @(negedge clk_i);
    chk("R11 stays stopped", beat_o, 0);

    // R6 full page, order bit set but ignored
    issue(CMD_MODE, COL_W'({3'd3,1'b1,3'd7}));
    issue(CMD_READ, 10'h3FE);
    for (int j = 0; j < 40; j++) begin
      chk("R6 full page col", col_o, (10'h3FE + j) & 10'h3FF);
      chk("R6 full page running", beat_o, 1);
      @(negedge clk_i);
    end
    cmd_i = CMD_STOP;
    @(negedge clk_i);
    cmd_i = CMD_NOP;
    chk("R6 R11 full page stopped", beat_o, 0);

    // R12 lockout after mode set
    @(negedge clk_i);
    cmd_i = CMD_MODE;
    addr_i = COL_W'({3'd3,1'b0,3'd1});
    @(negedge clk_i);
    cmd_i = CMD_READ;
    addr_i = 10'd5;
    @(negedge clk_i);
    cmd_i = CMD_NOP;
    chk("R12 read ignored", beat_o, 0);
    @(negedge clk_i);
    chk("R12 still idle", beat_o, 0);
    issue(CMD_READ, 10'd5);
    chk("R12 mode applied beat0", col_o, 10'd5);
    @(negedge clk_i);
    chk("R12 mode applied beat1", col_o, 10'd4);
    @(negedge clk_i);
    chk("R12 length 2", beat_o, 0);

    // R12 second mode set in lockout ignored
    @(negedge clk_i);
    cmd_i = CMD_MODE;
    addr_i = COL_W'({3'd3,1'b0,3'd2});
    @(negedge clk_i);
    cmd_i = CMD_MODE;
    addr_i = COL_W'({3'd3,1'b0,3'd0});
    @(negedge clk_i);
    cmd_i = CMD_NOP;
    issue(CMD_READ, 10'd0);
    repeat (3) @(negedge clk_i);
    chk("R12 length 4 kept", beat_o, 1);
    @(negedge clk_i);
    chk("R12 length 4 end", beat_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule